// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock Core

This block keeps wall-clock time as a plain count of seconds. A slow reference clock drives a programmable prescaler. The prescaler emits one tick every (reload + 1) reference cycles. Each tick advances a 32-bit seconds register and raises a sticky one-second event flag. The seconds register is compared against a 32-bit alarm value. When the alarm is armed and the two values are equal, a sticky alarm flag is raised.

Software reaches the core through a small memory-mapped port. It can write the time, the alarm and the prescaler reload, and it can read them back. It also arms the alarm and the interrupt sources through a control word. A scratchpad word has no side effect and serves as a marker that the stored time is valid.

The two event flags are sticky. Writing 0 to a flag bit clears it, and writing 1 leaves it as it is. Software can therefore rewrite the control word from a value it read earlier without losing an event that arrived in between. A ready bit reads low for a short window after every write, to stand for the hand-off of written data into the slow domain. A single level interrupt combines the two flags with their enables.

Top module: `sec_rtc_core`

## Requirements
- R1: After reset the following read as zero: the control word at offset 0x00 (apart from the ready bit 7, which reads 1), seconds (0x04), alarm (0x08), reload (0x0C) and scratchpad (0x34). The interrupt output is low after reset.
- R2: While run (control bit 0) is 1, the seconds value read at 0x04 equals its start value plus floor(n / (reload + 1)), where n is the number of clock edges since run was set and reload is the value at 0x0C. While run is 0 the seconds value holds, and a write to 0x04 loads it.
- R3: The seconds register advances from 0xFFFFFFFF to 0x00000000.
- R4: Every tick sets the one-second flag (control bit 6). One cycle after the seconds value equals the alarm value at 0x08 while the alarm arm bit (bit 2) is 1, the alarm flag (bit 4) is 1. A match while bit 2 is 0 leaves bit 4 at 0.
- R5: A control write with 0 in bit 4 or bit 6 clears that flag. A control write with 1 in either bit leaves that flag unchanged and never sets it.
- R6: The interrupt output is 1 exactly when (bit 6 and the one-second enable, bit 5) or (bit 4 and the alarm interrupt enable, bit 3) holds.
- R7: Control bit 7 is read-only. It reads 0 during the two cycles that follow any register write and 1 at all other times.
- R8: The scratchpad at 0x34 and the reload at 0x0C read back what was written, and a write to either changes no other register. Control bit 1 always reads 0, and offsets that are not mapped read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench sweeps several small reload values and samples the seconds register at every edge count over several periods. An off-by-one in the prescaler compare would stretch or shorten each second by a cycle and would be caught at the first boundary. Flags are written with 1 and then with 0 to separate preserve from clear, so a design that treated writes as plain stores would lose the pending event. The alarm is placed at a known tick, so a flag raised one cycle late or raised while unarmed shows up directly. The ready bit is sampled on each of the three cycles after a write, and the seconds register is stepped across the top of its range.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;
  localparam int RTC_AW = 6;
  localparam int RTC_DW = 32;

  localparam logic [RTC_AW-1:0] OFS_CTRL    = 6'h00;
  localparam logic [RTC_AW-1:0] OFS_SEC     = 6'h04;
  localparam logic [RTC_AW-1:0] OFS_ALARM   = 6'h08;
  localparam logic [RTC_AW-1:0] OFS_RELOAD  = 6'h0C;
  localparam logic [RTC_AW-1:0] OFS_SCRATCH = 6'h34;

  localparam int B_RUN  = 0;
  localparam int B_AARM = 2;
  localparam int B_AIE  = 3;
  localparam int B_AFLG = 4;
  localparam int B_HIE  = 5;
  localparam int B_HFLG = 6;
  localparam int B_RDY  = 7;

  typedef struct packed {
    logic hz_flag;
    logic hz_ie;
    logic al_flag;
    logic al_ie;
    logic al_arm;
    logic run;
  } ctrl_t;

  // Pack the control state into the software-visible word.
  function automatic logic [RTC_DW-1:0] ctrl_word(ctrl_t c, logic rdy);
    logic [RTC_DW-1:0] w;
    w         = '0;
    w[B_RUN]  = c.run;
    w[B_AARM] = c.al_arm;
    w[B_AIE]  = c.al_ie;
    w[B_AFLG] = c.al_flag;
    w[B_HIE]  = c.hz_ie;
    w[B_HFLG] = c.hz_flag;
    w[B_RDY]  = rdy;
    return w;
  endfunction

  // A sticky flag: a new event wins, and a write of 0 clears it.
  function automatic logic sticky_next(logic cur, logic set_ev, logic ctrl_wr, logic wbit);
    return set_ev | (cur & ~(ctrl_wr & ~wbit));
  endfunction

  function automatic logic [RTC_DW-1:0] sec_advance(logic [RTC_DW-1:0] s);
    return s + 32'd1;
  endfunction
endpackage

// File: rtl/sec_rtc_prescaler.sv
module sec_rtc_prescaler #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] reload,
  output logic         tick
);
  logic [W-1:0] cnt_q;

  // The >= compare ends the period at once if reload is lowered mid-count.
  assign tick = run && (cnt_q >= reload);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (!run)      cnt_q <= '0;
    else if (tick)      cnt_q <= '0;
    else                cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/sec_rtc_secs.sv
module sec_rtc_secs
  import sec_rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [RTC_DW-1:0] load_val,
  input  logic              tick,
  input  logic [RTC_DW-1:0] alarm_val,
  input  logic              alarm_arm,
  output logic [RTC_DW-1:0] sec_q,
  output logic              alarm_hit
);
  assign alarm_hit = alarm_arm && (sec_q == alarm_val);

  // A software load takes priority over a tick in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sec_q <= '0;
    else if (load)  sec_q <= load_val;
    else if (tick)  sec_q <= sec_advance(sec_q);
  end
endmodule

// File: rtl/sec_rtc_wrsync.sv
module sec_rtc_wrsync #(
  parameter int CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  output logic rdy
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] busy_q;

  assign rdy = (busy_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              busy_q <= '0;
    else if (wr)             busy_q <= CW'(CYC);
    else if (busy_q != '0)   busy_q <= busy_q - CW'(1);
  end
endmodule

// File: rtl/sec_rtc_core.sv
module sec_rtc_core
  import sec_rtc_pkg::*;
#(
  parameter int PRESC_W  = 32,
  parameter int BUSY_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [RTC_AW-1:0] bus_addr,
  input  logic [RTC_DW-1:0] bus_wdata,
  output logic [RTC_DW-1:0] bus_rdata,
  output logic              irq_o
);
  ctrl_t               ctrl_q;
  logic [RTC_DW-1:0]   alarm_q;
  logic [RTC_DW-1:0]   scratch_q;
  logic [PRESC_W-1:0]  reload_q;
  logic [RTC_DW-1:0]   sec_q;
  logic                tick;
  logic                alarm_hit;
  logic                wr_rdy;

  // Named write events for the checker.
  logic wr_ctrl, wr_sec, wr_alarm, wr_reload, wr_scratch;
  assign wr_ctrl    = bus_wr && (bus_addr == OFS_CTRL);
  assign wr_sec     = bus_wr && (bus_addr == OFS_SEC);
  assign wr_alarm   = bus_wr && (bus_addr == OFS_ALARM);
  assign wr_reload  = bus_wr && (bus_addr == OFS_RELOAD);
  assign wr_scratch = bus_wr && (bus_addr == OFS_SCRATCH);

  sec_rtc_prescaler #(.W(PRESC_W)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (ctrl_q.run),
    .reload (reload_q),
    .tick   (tick)
  );

  sec_rtc_secs u_secs (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (wr_sec),
    .load_val  (bus_wdata),
    .tick      (tick),
    .alarm_val (alarm_q),
    .alarm_arm (ctrl_q.al_arm),
    .sec_q     (sec_q),
    .alarm_hit (alarm_hit)
  );

  sec_rtc_wrsync #(.CYC(BUSY_CYC)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (bus_wr),
    .rdy   (wr_rdy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.run    <= bus_wdata[B_RUN];
        ctrl_q.al_arm <= bus_wdata[B_AARM];
        ctrl_q.al_ie  <= bus_wdata[B_AIE];
        ctrl_q.hz_ie  <= bus_wdata[B_HIE];
      end
      ctrl_q.hz_flag <= sticky_next(ctrl_q.hz_flag, tick, wr_ctrl, bus_wdata[B_HFLG]);
      ctrl_q.al_flag <= sticky_next(ctrl_q.al_flag, alarm_hit, wr_ctrl, bus_wdata[B_AFLG]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_q   <= '0;
      scratch_q <= '0;
      reload_q  <= '0;
    end else begin
      if (wr_alarm)   alarm_q   <= bus_wdata;
      if (wr_scratch) scratch_q <= bus_wdata;
      if (wr_reload)  reload_q  <= bus_wdata[PRESC_W-1:0];
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_CTRL:    bus_rdata = ctrl_word(ctrl_q, wr_rdy);
      OFS_SEC:     bus_rdata = sec_q;
      OFS_ALARM:   bus_rdata = alarm_q;
      OFS_RELOAD:  bus_rdata = RTC_DW'(reload_q);
      OFS_SCRATCH: bus_rdata = scratch_q;
      default:     bus_rdata = '0;
    endcase
  end

  assign irq_o = (ctrl_q.hz_flag & ctrl_q.hz_ie) | (ctrl_q.al_flag & ctrl_q.al_ie);
endmodule

// File: rtl/sec_rtc_checker.sv
module sec_rtc_checker
  import sec_rtc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              wr_sec,
  input logic              wr_ctrl,
  input logic              wd_aflg,
  input logic              tick,
  input logic              run,
  input logic [RTC_DW-1:0] sec_q,
  input logic              alarm_hit,
  input logic              al_flag,
  input logic              hz_flag,
  input logic              wr_rdy,
  input logic              irq_o
);
  // R2: no tick while counting is stopped
  a_r2_no_tick_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick);
  // R2: seconds hold without a tick or a load
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_sec) |=> $stable(sec_q));
  // R2, R3: a tick adds exactly one, modulo 2^32
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_sec) |=> (sec_q == $past(sec_q) + 32'd1));
  // R4: tick raises the one-second flag
  a_r4_hz_set: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> hz_flag);
  // R4: armed match raises the alarm flag
  a_r4_alarm_set: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |=> al_flag);
  // R5: only a control write with a 0 in bit 4 may drop the alarm flag
  a_r5_alarm_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (al_flag && !(wr_ctrl && !wd_aflg)) |=> al_flag);
  // R6: no interrupt without a pending flag
  a_r6_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (hz_flag || al_flag));
  // R7: ready is low on the two cycles after a write
  a_r7_busy_first: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> !wr_rdy);
  a_r7_busy_second: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> ##1 !wr_rdy);
endmodule

bind sec_rtc_core sec_rtc_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .wr_sec    (wr_sec),
  .wr_ctrl   (wr_ctrl),
  .wd_aflg   (bus_wdata[4]),
  .tick      (tick),
  .run       (ctrl_q.run),
  .sec_q     (sec_q),
  .alarm_hit (alarm_hit),
  .al_flag   (ctrl_q.al_flag),
  .hz_flag   (ctrl_q.hz_flag),
  .wr_rdy    (wr_rdy),
  .irq_o     (irq_o)
);

// File: tb/sim_sec_rtc_core.sv
module sim_sec_rtc_core;
  localparam logic [5:0] A_CTRL = 6'h00, A_SEC = 6'h04, A_ALM = 6'h08,
                         A_REL = 6'h0C, A_SCR = 6'h34;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sec_rtc_core u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // Seconds expected after n edges of counting with a given reload.
  function automatic logic [31:0] exp_secs(logic [31:0] start, int n, int rel);
    return start + 32'(n / (rel + 1));
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
    end
  endtask

  // Called at a falling edge; the write lands on the next rising edge.
  task automatic wr(logic [5:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic idle(int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    idle(2);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    rd(A_CTRL, v); check("R1 ctrl", v, 32'h80);
    rd(A_SEC, v);  check("R1 sec", v, 0);
    rd(A_ALM, v);  check("R1 alarm", v, 0);
    rd(A_REL, v);  check("R1 reload", v, 0);
    rd(A_SCR, v);  check("R1 scratch", v, 0);
    check("R1 irq", 32'(irq_o), 0);

    // R2 sweep over small reloads and every edge count
    for (int rel = 0; rel < 5; rel++) begin
      for (int k = 0; k <= 3 * (rel + 1) + 1; k++) begin
        wr(A_CTRL, 0); wr(A_SEC, 32'd100); wr(A_REL, 32'(rel));
        wr(A_CTRL, 32'h1);
        idle(k);
        rd(A_SEC, v); check("R2 count", v, exp_secs(32'd100, k, rel));
      end
    end

    // R2 stop holds the value
    wr(A_CTRL, 0);
    rd(A_SEC, v); idle(10); rd(A_SEC, v2); check("R2 hold", v2, v);

    // R3 wrap
    wr(A_SEC, 32'hFFFF_FFFF); wr(A_REL, 0); wr(A_CTRL, 32'h1);
    rd(A_SEC, v); check("R3 before", v, 32'hFFFF_FFFF);
    idle(1); rd(A_SEC, v); check("R3 wrap", v, 0);

    // R4/R5/R6/R7 one-second flag
    wr(A_CTRL, 0); wr(A_SEC, 0); wr(A_REL, 32'd9);
    wr(A_CTRL, 32'h21);
    idle(9);
    rd(A_CTRL, v); check("R4 hz not yet", 32'(v[6]), 0);
    check("R6 irq low", 32'(irq_o), 0);
    idle(1);
    rd(A_CTRL, v); check("R4 hz set", 32'(v[6]), 1);
    check("R6 irq hz", 32'(irq_o), 1);
    wr(A_CTRL, 32'h61);
    rd(A_CTRL, v); check("R5 hz kept", 32'(v[6]), 1);
    wr(A_CTRL, 32'h21);
    rd(A_CTRL, v); check("R5 hz cleared", 32'(v[6]), 0);
    check("R6 irq cleared", 32'(irq_o), 0);
    check("R7 busy 1", 32'(v[7]), 0);
    idle(1); rd(A_CTRL, v); check("R7 busy 2", 32'(v[7]), 0);
    idle(1); rd(A_CTRL, v); check("R7 ready", 32'(v[7]), 1);

    // R4/R5/R6 alarm, armed
    wr(A_CTRL, 0); wr(A_SEC, 5); wr(A_ALM, 7); wr(A_REL, 1);
    wr(A_CTRL, 32'h0D);
    idle(4);
    rd(A_CTRL, v); check("R4 alarm not yet", 32'(v[4]), 0);
    check("R6 hz masked", 32'(irq_o), 0);
    idle(1);
    rd(A_CTRL, v); check("R4 alarm set", 32'(v[4]), 1);
    check("R6 irq alarm", 32'(irq_o), 1);
    idle(1);
    wr(A_CTRL, 32'h1D);
    rd(A_CTRL, v); check("R5 alarm kept", 32'(v[4]), 1);
    wr(A_CTRL, 32'h0D);
    rd(A_CTRL, v); check("R5 alarm cleared", 32'(v[4]), 0);
    check("R6 irq after clear", 32'(irq_o), 0);

    // R4 match while unarmed
    wr(A_CTRL, 0); wr(A_SEC, 5); wr(A_ALM, 7); wr(A_REL, 1);
    wr(A_CTRL, 32'h09);
    idle(8);
    rd(A_SEC, v); check("R4 unarmed sec", v, 32'd9);
    rd(A_CTRL, v); check("R4 unarmed flag", 32'(v[4]), 0);
    check("R6 unarmed irq", 32'(irq_o), 0);

    // R8 scratchpad, reload, reserved bits, unmapped
    wr(A_CTRL, 0); wr(A_SEC, 32'h55); wr(A_REL, 32'd1000); idle(3);
    wr(A_SCR, 32'h1234_5678); idle(2);
    rd(A_SCR, v); check("R8 scratch", v, 32'h1234_5678);
    rd(A_CTRL, v); check("R8 ctrl untouched", v, 32'h80);
    rd(A_SEC, v); check("R8 sec untouched", v, 32'h55);
    rd(A_REL, v); check("R8 reload", v, 32'd1000);
    wr(A_CTRL, 32'h2F); idle(2);
    rd(A_CTRL, v); check("R8 ctrl bits", v, 32'hAD);
    rd(6'h10, v); check("R8 unmapped", v, 0);
    rd(A_SCR, v); check("R8 scratch kept", v, 32'h1234_5678);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule